// File: doc/BRIEF.md
# Processor Special Register Bank

This block holds the special-purpose registers of a 32-bit embedded CPU core. The trap-table base register points at the interrupt and exception vector table. Two multiply-result registers hold the low and high words of a 64-bit product. A read-only identification word reports the core type, a revision byte and the opcode of the last undefined instruction. A read-only debug base register returns a fixed address.

The CPU reaches every register through one select-addressed port. A 3-bit select picks the register. Reads are combinational and writes take effect on the next rising clock edge. The multiplier has its own update path, which loads both result words at once. An exception strobe captures the 16-bit opcode of an undefined instruction into the identification word.

Top module: `spr_bank`

## Requirements
- R1: After reset, select code 0 (trap-table base) reads the value of parameter TRAP_RESET, with its bits 9:0 forced to zero.
- R2: Bits 9:0 of the trap-table base always read zero and ignore writes. Bits 31:10 take the written value when select 0 is written.
- R3: Select code 1 (multiply low) and select code 2 (multiply high) are 32-bit registers that software can read and write. A write to one of them leaves the other unchanged.
- R4: When mul_we is high at a rising edge, bits 31:0 of mul_product are loaded into multiply low and bits 63:32 are loaded into multiply high.
- R5: When mul_we and a software write to a multiply register fall in the same cycle, the product value is stored and the software value is dropped.
- R6: Reset does not change the multiply registers. Values stored before a reset pulse still read back after it.
- R7: Select code 3 (identification) reads 0x06 in bits 31:24 and parameter REVISION in bits 23:16. Writes to this register have no effect.
- R8: Bits 15:0 of the identification word load undef_code on any edge where undef_valid is high. They hold that value otherwise and reset to 0x0000.
- R9: Select code 4 (debug base) always reads 0x00060000. Writes to it have no effect.
- R10: Select codes 5, 6 and 7 read zero. Writes to them change no register.
- R11: A write is seen on rd_data right after the next rising edge, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Register select for reads and writes |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Combinational read data for sel |
| mul_we | input | 1 | Multiplier result update strobe |
| mul_product | input | 64 | 64-bit product from the multiplier |
| undef_valid | input | 1 | Undefined-instruction exception strobe |
| undef_code | input | 16 | Opcode of the faulting instruction |

## Verification
The bench builds the bank with TRAP_RESET = 0x00400000 and REVISION = 0xA7, not the default values. This lets a check tell a correct reset load apart from a value that was hard-coded to the default. The revision byte is nonzero and differs from the type byte, so a swapped or missing field in the identification word shows up in every read of it. With these values, one read of each register after reset confirms that the parameters reach the registers.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;
  localparam int OPC_W  = 16;

  typedef enum logic [SEL_W-1:0] {
    SEL_TRAP  = 3'd0,
    SEL_MLO   = 3'd1,
    SEL_MHI   = 3'd2,
    SEL_IDENT = 3'd3,
    SEL_DBG   = 3'd4
  } spr_sel_e;

  localparam logic [7:0]        CORE_TYPE = 8'h06;
  localparam logic [WORD_W-1:0] DBG_BASE  = 32'h0006_0000;

  // Clear the low 'bits' bits of an address.
  function automatic logic [WORD_W-1:0] align_down(input logic [WORD_W-1:0] addr,
                                                   input int unsigned bits);
    logic [WORD_W-1:0] keep;
    keep = ~((WORD_W'(1) << bits) - WORD_W'(1));
    return addr & keep;
  endfunction

  // Put together the identification word.
  function automatic logic [WORD_W-1:0] ident_word(input logic [7:0] rev,
                                                   input logic [OPC_W-1:0] opc);
    return {CORE_TYPE, rev, opc};
  endfunction

endpackage

// File: rtl/spr_trap_base.sv
module spr_trap_base #(
  parameter int              W       = 32,
  parameter int              ALIGN   = 10,
  parameter logic [W-1:0]    RST_VAL = 32'h00C0_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import spr_pkg::*;

  localparam logic [W-1:0] RST_AL = align_down(RST_VAL, ALIGN);

  logic [W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base_q <= RST_AL;
    else if (we) base_q <= align_down(wdata, ALIGN);
  end

  assign q = base_q;
endmodule

// File: rtl/spr_mul_pair.sv
module spr_mul_pair #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           hw_we,
  input  logic [2*W-1:0] product,
  input  logic [1:0]     sw_we,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   lo_q,
  output logic [W-1:0]   hi_q
);
  logic [1:0][W-1:0] word;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [W-1:0] r_q;
    // No reset by design; the multiplier path wins over software.
    always_ff @(posedge clk) begin
      if (hw_we)         r_q <= product[h*W +: W];
      else if (sw_we[h]) r_q <= wdata;
    end
    assign word[h] = r_q;
  end

  assign lo_q = word[0];
  assign hi_q = word[1];
endmodule

// File: rtl/spr_ident.sv
module spr_ident #(
  parameter int         W     = 32,
  parameter int         OW    = 16,
  parameter logic [7:0] REV   = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [OW-1:0] code,
  output logic [OW-1:0] opc_q,
  output logic [W-1:0]  id_word
);
  import spr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opc_q <= '0;
    else if (capture) opc_q <= code;
  end

  assign id_word = ident_word(REV, opc_q);
endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_pkg::*;
#(
  parameter logic [WORD_W-1:0] TRAP_RESET = 32'h00C0_0000,
  parameter int                TRAP_ALIGN = 10,
  parameter logic [7:0]        REVISION   = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                mul_we,
  input  logic [2*WORD_W-1:0] mul_product,
  input  logic                undef_valid,
  input  logic [OPC_W-1:0]    undef_code
);

  // Named internal events for the checker.
  logic              trap_wr;
  logic [1:0]        mul_sw_wr;
  logic [WORD_W-1:0] trap_q, mul_lo_q, mul_hi_q, id_q;
  logic [OPC_W-1:0]  opc_q;

  assign trap_wr      = wr_en && (sel == SEL_TRAP);
  assign mul_sw_wr[0] = wr_en && (sel == SEL_MLO);
  assign mul_sw_wr[1] = wr_en && (sel == SEL_MHI);

  spr_trap_base #(
    .W(WORD_W), .ALIGN(TRAP_ALIGN), .RST_VAL(TRAP_RESET)
  ) u_trap (
    .clk(clk), .rst_n(rst_n), .we(trap_wr), .wdata(wr_data), .q(trap_q)
  );

  spr_mul_pair #(.W(WORD_W)) u_mul (
    .clk(clk), .hw_we(mul_we), .product(mul_product),
    .sw_we(mul_sw_wr), .wdata(wr_data), .lo_q(mul_lo_q), .hi_q(mul_hi_q)
  );

  spr_ident #(.W(WORD_W), .OW(OPC_W), .REV(REVISION)) u_ident (
    .clk(clk), .rst_n(rst_n), .capture(undef_valid), .code(undef_code),
    .opc_q(opc_q), .id_word(id_q)
  );

  always_comb begin
    case (sel)
      SEL_TRAP:  rd_data = trap_q;
      SEL_MLO:   rd_data = mul_lo_q;
      SEL_MHI:   rd_data = mul_hi_q;
      SEL_IDENT: rd_data = id_q;
      SEL_DBG:   rd_data = DBG_BASE;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spr_bank_chk.sv
module spr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  sel,
  input logic        wr_en,
  input logic [31:0] rd_data,
  input logic        mul_we,
  input logic [63:0] mul_product,
  input logic        undef_valid,
  input logic [15:0] undef_code,
  input logic [31:0] mul_lo_q,
  input logic [31:0] mul_hi_q,
  input logic [15:0] opc_q
);
  // R2
  trap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> (rd_data[9:0] == 10'd0));

  // R4
  mul_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_we |=> (mul_lo_q == $past(mul_product[31:0])));

  // R4
  mul_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_we |=> (mul_hi_q == $past(mul_product[63:32])));

  // R5
  mul_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_we && wr_en && sel == 3'd1) |=> (rd_data == $past(mul_product[31:0]) || sel != 3'd1));

  // R7
  id_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd3) |-> (rd_data[31:24] == 8'h06));

  // R8
  opc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_valid |=> (opc_q == $past(undef_code)));

  // R8
  opc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !undef_valid |=> $stable(opc_q));

  // R9
  dbg_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd4) |-> (rd_data == 32'h0006_0000));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > 3'd4) |-> (rd_data == 32'd0));
endmodule

bind spr_bank spr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_data(rd_data),
  .mul_we(mul_we), .mul_product(mul_product), .undef_valid(undef_valid),
  .undef_code(undef_code), .mul_lo_q(mul_lo_q), .mul_hi_q(mul_hi_q), .opc_q(opc_q)
);

// File: tb/test_spr_bank.sv
module test_spr_bank;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] T_RST      = 32'h0040_0000;
  localparam logic [7:0]  T_REV      = 8'hA7;
  localparam logic [31:0] ID_BASE    = {8'h06, T_REV, 16'h0000};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  sel = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        mul_we = 0;
  logic [63:0] mul_product = 0;
  logic        undef_valid = 0;
  logic [15:0] undef_code = 0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_bank #(.TRAP_RESET(T_RST), .REVISION(T_REV)) i_spr_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mul_we(mul_we), .mul_product(mul_product),
    .undef_valid(undef_valid), .undef_code(undef_code)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FC00, 8'd2},  // R2 low bits dropped
    '{1'b1, 3'd0, 32'h0000_03FF, 32'h0000_0000, 8'd2},  // R2
    '{1'b1, 3'd0, 32'h1234_5678, 32'h1234_5400, 8'd2},  // R2
    '{1'b1, 3'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd3},  // R3
    '{1'b1, 3'd2, 32'h0BAD_F00D, 32'h0BAD_F00D, 8'd3},  // R3
    '{1'b0, 3'd1, 32'h0000_0000, 32'hDEAD_BEEF, 8'd3},  // R3 low untouched
    '{1'b1, 3'd3, 32'hFFFF_FFFF, ID_BASE,       8'd7},  // R7 read-only
    '{1'b1, 3'd4, 32'hFFFF_FFFF, 32'h0006_0000, 8'd9},  // R9
    '{1'b1, 3'd5, 32'h5555_5555, 32'h0000_0000, 8'd10}, // R10
    '{1'b1, 3'd7, 32'hAAAA_AAAA, 32'h0000_0000, 8'd10}, // R10
    '{1'b0, 3'd0, 32'h0000_0000, 32'h1234_5400, 8'd10}  // R10 trap unaffected
  };

  task automatic check(input logic [2:0] s, input logic [31:0] expv, input string tag);
    sel = s;
    #1;
    checks++;
    if (rd_data !== expv) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%08h expected=%08h", tag, s, rd_data, expv);
    end
  endtask

  task automatic write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    sel = s; wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;

    check(3'd0, T_RST, "R1 reset trap base");
    check(3'd3, ID_BASE, "R7 R8 reset ident");
    check(3'd4, 32'h0006_0000, "R9 reset debug base");
    check(3'd6, 32'h0, "R10 reset unmapped");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VECS[i].sel; wr_en = VECS[i].wr; wr_data = VECS[i].wdata;
      @(posedge clk); #1;
      wr_en = 0;
      check(VECS[i].sel, VECS[i].expv, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R11: not visible before the edge
    @(negedge clk);
    sel = 3'd1; wr_en = 1; wr_data = 32'h0F0F_0F0F;
    #1;
    check(3'd1, 32'hDEAD_BEEF, "R11 before edge");
    @(posedge clk); #1;
    wr_en = 0;
    check(3'd1, 32'h0F0F_0F0F, "R11 after edge");

    // R4: multiplier update
    @(negedge clk);
    mul_we = 1; mul_product = 64'h0123_4567_89AB_CDEF;
    @(posedge clk); #1;
    mul_we = 0;
    check(3'd1, 32'h89AB_CDEF, "R4 low word");
    check(3'd2, 32'h0123_4567, "R4 high word");

    // R5: priority over a software write
    @(negedge clk);
    mul_we = 1; mul_product = 64'hAAAA_0000_BBBB_1111;
    sel = 3'd1; wr_en = 1; wr_data = 32'h1111_1111;
    @(posedge clk); #1;
    mul_we = 0; wr_en = 0;
    check(3'd1, 32'hBBBB_1111, "R5 low priority");
    check(3'd2, 32'hAAAA_0000, "R5 high from product");

    // R8: capture and hold
    @(negedge clk);
    undef_valid = 1; undef_code = 16'hBEEF;
    @(posedge clk); #1;
    undef_valid = 0; undef_code = 16'h1234;
    check(3'd3, ID_BASE | 32'h0000_BEEF, "R8 capture");
    @(posedge clk); #1;
    check(3'd3, ID_BASE | 32'h0000_BEEF, "R8 hold");
    write(3'd3, 32'h0000_0000);
    check(3'd3, ID_BASE | 32'h0000_BEEF, "R7 write ignored");

    // R6 / R1 / R8: reset mid-run
    @(negedge clk); rst_n = 0;
    #1;
    check(3'd0, T_RST, "R1 reset reload");
    @(negedge clk); rst_n = 1;
    check(3'd1, 32'hBBBB_1111, "R6 low kept");
    check(3'd2, 32'hAAAA_0000, "R6 high kept");
    check(3'd3, ID_BASE, "R8 opcode reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule